// File: doc/BRIEF.md
# SPI Frame FIFO Transfer Engine

This block moves complete Ethernet frames between on-chip byte streams and the packet queue of an external network controller reached over SPI. A send request makes the engine emit a five-byte header, followed by the payload bytes it pulls from a valid/ready input stream. The header holds the write opcode, a rolling frame tag, a reserved zero byte and the frame length, low byte first.

A fetch request makes the engine emit a fixed nine-byte command prefix, made of the read opcode and eight zeros. It then clocks in as many payload bytes as the requester asked for. Each received payload byte appears once on a valid-only output stream. The bytes that arrive during the prefix are dropped.

The engine handles one frame at a time. Chip select frames the whole transfer. When the send stream runs dry, the serial clock stops rather than padding the frame. A one-cycle completion pulse closes every frame.

Top module: `spi_frame_engine`

## Requirements
- R1: After reset the outputs are idle: cs_n=1, sclk=0, busy=0, done=0, tx_ready=0, rx_valid=0.
- R2: A send frame starts with header byte 0 equal to the write opcode (parameter, default 8'hC0) and header byte 2 equal to 8'h00. Every byte goes out MSB first.
- R3: Header byte 1 is {2'b00, tag}, where tag is a 6-bit counter. The counter starts at 0 after reset, rises by one after each completed send frame and wraps from 63 to 0. Fetch frames leave it unchanged.
- R4: Header bytes 3 and 4 carry tx_total_len low byte then high byte. Exactly tx_seg_len payload bytes follow, taken in stream order, even when tx_total_len differs from tx_seg_len.
- R5: A fetch frame sends 9 prefix bytes: the read opcode (parameter, default 8'h80) and then eight 8'h00 bytes. It sends 8'h00 during every payload byte.
- R6: A fetch frame delivers exactly rx_len bytes on rx_valid/rx_data, in order. These are the bytes received after the prefix. Prefix bytes and bytes received during a send frame are never forwarded.
- R7: The SPI mode is clock polarity 0, clock phase 1. sclk idles low. mosi changes only on a rising sclk edge. miso is sampled on the falling edge.
- R8: cs_n stays low from the first header or prefix byte through the last byte of the frame. sclk never pulses while cs_n is high.
- R9: While the send stream has no valid byte, sclk and mosi stay still. No filler byte is inserted, so the payload is complete and in order whatever the stall pattern.
- R10: done is a single-cycle pulse, with cs_n high and busy low, at the end of every frame. busy is high throughout a frame. A request raised while busy is ignored.
- R11: If tx_req and rx_req are both raised in the same idle cycle, the send frame is started and the fetch request is dropped.
- R12: When tx_seg_len=0, only the header is sent. When rx_len=0, only the prefix is sent and nothing is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_req | input | 1 | Start a send frame (sampled when idle) |
| tx_total_len | input | 16 | Length value written into the header |
| tx_seg_len | input | 16 | Number of payload bytes taken from the stream |
| rx_req | input | 1 | Start a fetch frame (sampled when idle) |
| rx_len | input | 16 | Number of payload bytes to fetch |
| tx_valid | input | 1 | Send stream byte valid |
| tx_data | input | 8 | Send stream byte |
| tx_ready | output | 1 | Engine accepts a send stream byte this cycle |
| rx_valid | output | 1 | Fetched payload byte valid (one cycle) |
| rx_data | output | 8 | Fetched payload byte |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| sclk | output | 1 | SPI serial clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |

## Verification
The assertions watch the cycle-level rules on every cycle:
- mosi moves only on a rising sclk edge;
- sclk never pulses without chip select, and chip select holds for the whole frame;
- the shift unit is only started when it is idle;
- the frame tag only steps by one at a frame end;
- fetched bytes never appear during a send frame;
- sclk freezes while the send stream is empty;
- done is a lone pulse with chip select released.

The content rules can only be shown by the bench scenarios. These are header byte values and order, the length field differing from the payload count, the prefix bytes and their being dropped, the received byte values, tag wrap after 64 frames, request priority, requests ignored while busy, and zero-length frames.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;
    localparam int LEN_W   = 16;
    localparam int HDR_LEN = 5;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HDR,
        S_TXPAY,
        S_PRE,
        S_RXPAY,
        S_DRAIN
    } sfe_state_e;

    typedef logic [LEN_W-1:0] len_t;
endpackage

// File: rtl/sfe_byte_shift.sv
// One SPI byte, polarity 0 / phase 1: drive on the rising edge, sample on the falling edge.
module sfe_byte_shift #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] byte_in,
    input  logic       miso,
    output logic       busy,
    output logic       sclk,
    output logic       mosi,
    output logic       byte_done,
    output logic [7:0] byte_rx
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

    typedef struct packed {
        logic             active;
        logic             sclk;
        logic             mosi;
        logic             done;
        logic [7:0]       sh;
        logic [7:0]       rx;
        logic [2:0]       bitc;
        logic [DIV_W-1:0] div;
    } shift_t;

    shift_t shift_q, shift_d;

    always_comb begin
        shift_d      = shift_q;
        shift_d.done = 1'b0;
        if (!shift_q.active) begin
            if (start) begin
                shift_d.active = 1'b1;
                shift_d.sh     = byte_in;
                shift_d.bitc   = 3'd0;
                shift_d.div    = '0;
                shift_d.sclk   = 1'b0;
            end
        end else if (shift_q.div != DIV_LAST) begin
            shift_d.div = shift_q.div + 1'b1;
        end else begin
            shift_d.div = '0;
            if (!shift_q.sclk) begin
                shift_d.sclk = 1'b1;
                shift_d.mosi = shift_q.sh[7];
                shift_d.sh   = {shift_q.sh[6:0], 1'b0};
            end else begin
                shift_d.sclk = 1'b0;
                shift_d.rx   = {shift_q.rx[6:0], miso};
                shift_d.bitc = shift_q.bitc + 3'd1;
                if (shift_q.bitc == 3'd7) begin
                    shift_d.active = 1'b0;
                    shift_d.done   = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= shift_d;
    end

    assign busy      = shift_q.active;
    assign sclk      = shift_q.sclk;
    assign mosi      = shift_q.mosi;
    assign byte_done = shift_q.done;
    assign byte_rx   = shift_q.rx;

    // R7: data out only moves on a rising clock edge
    a_r7_mosi_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(shift_q.mosi) |-> $rose(shift_q.sclk));

    // R7: a new byte is only launched into an idle shifter
    a_r7_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !shift_q.active);
endmodule

// File: rtl/sfe_seq.sv
// Frame sequencer: header / prefix / payload ordering, tag counter, chip select.
module sfe_seq
    import spi_frame_pkg::*;
#(
    parameter logic [7:0] RD_OP   = 8'h80,
    parameter logic [7:0] WR_OP   = 8'hC0,
    parameter int         FID_W   = 6,
    parameter int         PRE_LEN = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_req,
    input  len_t       tx_total_len,
    input  len_t       tx_seg_len,
    input  logic       rx_req,
    input  len_t       rx_len,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    output logic       tx_ready,
    input  logic       sh_busy,
    input  logic       sh_done,
    input  logic [7:0] sh_rx,
    output logic       start,
    output logic [7:0] start_byte,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       cs_n,
    output logic       busy,
    output logic       done
);
    localparam int IDX_W = $clog2(PRE_LEN);
    localparam logic [IDX_W-1:0] HDR_LAST = IDX_W'(HDR_LEN - 1);
    localparam logic [IDX_W-1:0] PRE_LAST = IDX_W'(PRE_LEN - 1);

    typedef struct packed {
        sfe_state_e       st;
        logic [IDX_W-1:0] idx;
        len_t             rem;
        len_t             tot;
        logic [FID_W-1:0] fid;
        logic             sel;
        logic             done;
        logic             is_tx;
        logic             fwd;
    } seq_t;

    seq_t seq_q, seq_d;
    logic [7:0] hdr_byte;

    always_comb begin
        case (seq_q.idx)
            IDX_W'(0): hdr_byte = WR_OP;
            IDX_W'(1): hdr_byte = 8'(seq_q.fid);
            IDX_W'(2): hdr_byte = 8'h00;
            IDX_W'(3): hdr_byte = seq_q.tot[7:0];
            default:   hdr_byte = seq_q.tot[15:8];
        endcase
    end

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        start      = 1'b0;
        start_byte = 8'h00;
        tx_ready   = 1'b0;
        case (seq_q.st)
            S_IDLE: begin
                if (tx_req) begin
                    seq_d.st    = S_HDR;
                    seq_d.idx   = '0;
                    seq_d.sel   = 1'b1;
                    seq_d.tot   = tx_total_len;
                    seq_d.rem   = tx_seg_len;
                    seq_d.is_tx = 1'b1;
                end else if (rx_req) begin
                    seq_d.st    = S_PRE;
                    seq_d.idx   = '0;
                    seq_d.sel   = 1'b1;
                    seq_d.rem   = rx_len;
                    seq_d.is_tx = 1'b0;
                end
            end
            S_HDR: begin
                if (!sh_busy) begin
                    start      = 1'b1;
                    start_byte = hdr_byte;
                    seq_d.fwd  = 1'b0;
                    if (seq_q.idx == HDR_LAST) begin
                        seq_d.idx = '0;
                        seq_d.st  = (seq_q.rem == '0) ? S_DRAIN : S_TXPAY;
                    end else begin
                        seq_d.idx = seq_q.idx + 1'b1;
                    end
                end
            end
            S_TXPAY: begin
                tx_ready = !sh_busy;
                if (!sh_busy && tx_valid) begin
                    start      = 1'b1;
                    start_byte = tx_data;
                    seq_d.fwd  = 1'b0;
                    seq_d.rem  = seq_q.rem - 1'b1;
                    if (seq_q.rem == len_t'(1)) seq_d.st = S_DRAIN;
                end
            end
            S_PRE: begin
                if (!sh_busy) begin
                    start      = 1'b1;
                    start_byte = (seq_q.idx == '0) ? RD_OP : 8'h00;
                    seq_d.fwd  = 1'b0;
                    if (seq_q.idx == PRE_LAST) begin
                        seq_d.idx = '0;
                        seq_d.st  = (seq_q.rem == '0) ? S_DRAIN : S_RXPAY;
                    end else begin
                        seq_d.idx = seq_q.idx + 1'b1;
                    end
                end
            end
            S_RXPAY: begin
                if (!sh_busy) begin
                    start      = 1'b1;
                    start_byte = 8'h00;
                    seq_d.fwd  = 1'b1;
                    seq_d.rem  = seq_q.rem - 1'b1;
                    if (seq_q.rem == len_t'(1)) seq_d.st = S_DRAIN;
                end
            end
            S_DRAIN: begin
                if (!sh_busy) begin
                    seq_d.st   = S_IDLE;
                    seq_d.sel  = 1'b0;
                    seq_d.done = 1'b1;
                    if (seq_q.is_tx) seq_d.fid = seq_q.fid + 1'b1;
                end
            end
            default: seq_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign rx_valid = sh_done && seq_q.fwd;
    assign rx_data  = sh_rx;
    assign cs_n     = !seq_q.sel;
    assign busy     = (seq_q.st != S_IDLE);
    assign done     = seq_q.done;

    // R3: the tag moves only at a frame end, and only by one
    a_r3_tag_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(seq_q.fid) |-> (seq_q.done && seq_q.fid == $past(seq_q.fid) + 1'b1));

    // R6: nothing is forwarded while a send frame runs
    a_r6_no_forward_on_send: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !seq_q.is_tx);

    // R8: chip select held for every non-idle state
    a_r8_select_held: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st != S_IDLE) |-> seq_q.sel);
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
    import spi_frame_pkg::*;
#(
    parameter int         HALF_DIV = 2,
    parameter logic [7:0] RD_OP    = 8'h80,
    parameter logic [7:0] WR_OP    = 8'hC0,
    parameter int         FID_W    = 6,
    parameter int         PRE_LEN  = 9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_req,
    input  logic [15:0] tx_total_len,
    input  logic [15:0] tx_seg_len,
    input  logic        rx_req,
    input  logic [15:0] rx_len,
    input  logic        tx_valid,
    input  logic [7:0]  tx_data,
    output logic        tx_ready,
    output logic        rx_valid,
    output logic [7:0]  rx_data,
    output logic        busy,
    output logic        done,
    output logic        sclk,
    output logic        cs_n,
    output logic        mosi,
    input  logic        miso
);
    logic       sh_busy, sh_done, sh_start;
    logic [7:0] sh_rx, sh_byte;

    sfe_seq #(
        .RD_OP(RD_OP), .WR_OP(WR_OP), .FID_W(FID_W), .PRE_LEN(PRE_LEN)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .tx_req(tx_req), .tx_total_len(tx_total_len), .tx_seg_len(tx_seg_len),
        .rx_req(rx_req), .rx_len(rx_len),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .sh_busy(sh_busy), .sh_done(sh_done), .sh_rx(sh_rx),
        .start(sh_start), .start_byte(sh_byte),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .cs_n(cs_n), .busy(busy), .done(done)
    );

    sfe_byte_shift #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .start(sh_start), .byte_in(sh_byte), .miso(miso),
        .busy(sh_busy), .sclk(sclk), .mosi(mosi),
        .byte_done(sh_done), .byte_rx(sh_rx)
    );

    // R8: no clock pulse without chip select
    a_r8_sclk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    // R9: an empty send stream freezes the serial lines
    a_r9_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && !tx_valid) |=> ($stable(sclk) && $stable(mosi)));

    // R10: completion is a lone pulse with the bus released
    a_r10_done_released: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !busy));

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/tb_spi_frame_engine.sv
module tb_spi_frame_engine;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        tx_req = 1'b0, rx_req = 1'b0;
    logic [15:0] tx_total_len = '0, tx_seg_len = '0, rx_len = '0;
    logic        tx_valid = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        tx_ready, rx_valid, busy, done, sclk, cs_n, mosi;
    logic [7:0]  rx_data;
    logic        miso = 1'b0;

    spi_frame_engine dut (
        .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_total_len(tx_total_len),
        .tx_seg_len(tx_seg_len), .rx_req(rx_req), .rx_len(rx_len),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy), .done(done),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    int total = 0, bad = 0;
    int exp_fid = 0;

    // serial slave model
    int frames = 0, rstart = 0, grise = 0, stray = 0, gbits = 0, gcount = 0;
    logic [7:0] gbyte [0:1023];
    logic [7:0] mshift = '0;
    logic [7:0] rxbuf [0:255];
    int rxn = 0, donecnt = 0;

    function automatic logic [7:0] pat(int k);
        return 8'((k * 37 + 11) ^ 8'h5A);
    endfunction

    function automatic logic [7:0] srcb(int i);
        return 8'(i * 13 + 7);
    endfunction

    function automatic logic [7:0] gb(int k);
        return gbyte[k % 1024];
    endfunction

    always @(negedge cs_n) begin
        frames = frames + 1;
        rstart = grise;
    end

    always @(posedge sclk) begin
        if (cs_n) stray = stray + 1;
        else begin
            logic [7:0] b;
            b = pat((grise - rstart) / 8);
            miso <= b[7 - ((grise - rstart) % 8)];
        end
        grise = grise + 1;
    end

    always @(negedge sclk) begin
        mshift = {mshift[6:0], mosi};
        gbits = gbits + 1;
        if (gbits % 8 == 0) begin
            gbyte[gcount % 1024] = mshift;
            gcount = gcount + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            rxbuf[rxn % 256] = rx_data;
            rxn = rxn + 1;
        end
        if (rst_n && done) donecnt = donecnt + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // R1
    task automatic t_reset();
        @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs_n idle", cs_n, 1);
        chk(sclk == 1'b0, "R1 sclk idle", sclk, 0);
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done idle", {busy, done}, 0);
        chk(tx_ready == 1'b0 && rx_valid == 1'b0, "R1 stream idle", {tx_ready, rx_valid}, 0);
    endtask

    // mode 0 plain, 1 stalled stream, 2 request while busy, 3 both requests at once
    task automatic run_tx(input int tlen, input int seg, input int mode);
        int d0, rx0, f0, fr0, idx, cyc, n, errs;
        bit hs;
        d0 = donecnt; rx0 = rxn; f0 = gcount; fr0 = frames;
        @(negedge clk);
        tx_req = 1'b1; tx_total_len = 16'(tlen); tx_seg_len = 16'(seg);
        if (mode == 3) begin rx_req = 1'b1; rx_len = 16'd4; end
        @(negedge clk);
        tx_req = 1'b0; rx_req = 1'b0;
        idx = 0; hs = 1'b0; cyc = 0;
        while (donecnt == d0 && cyc < 20000) begin
            if (hs) idx++;
            tx_valid = (idx < seg) && !(mode == 1 && (cyc % 9) < 5);
            tx_data  = srcb(idx);
            hs = tx_valid && tx_ready;
            if (mode == 2 && cyc == 30) begin
                chk(busy == 1'b1, "R10 busy mid-frame", busy, 1);
                rx_req = 1'b1; rx_len = 16'd2;
            end
            if (mode == 2 && cyc == 31) rx_req = 1'b0;
            @(negedge clk);
            cyc++;
        end
        tx_valid = 1'b0;
        chk(cyc < 20000, "R10 send frame completes", cyc, 20000);
        repeat (40) @(negedge clk);
        chk(frames - fr0 == 1, "R10 R11 exactly one frame", frames - fr0, 1);
        n = gcount - f0;
        chk(n == 5 + seg, "R4 R12 byte count", n, 5 + seg);
        chk(gb(f0) == 8'hC0, "R2 write opcode", gb(f0), 8'hC0);
        chk(gb(f0 + 1) == {2'b00, 6'(exp_fid)}, "R3 frame tag", gb(f0 + 1), exp_fid);
        chk(gb(f0 + 2) == 8'h00, "R2 reserved byte", gb(f0 + 2), 0);
        chk(gb(f0 + 3) == 8'(tlen), "R4 length low", gb(f0 + 3), tlen & 8'hFF);
        chk(gb(f0 + 4) == 8'(tlen >> 8), "R4 length high", gb(f0 + 4), tlen >> 8);
        errs = 0;
        for (int i = 0; i < seg; i++) if (gb(f0 + 5 + i) != srcb(i)) errs++;
        if (mode == 1) chk(errs == 0, "R9 payload under stalls", errs, 0);
        else           chk(errs == 0, "R4 payload bytes", errs, 0);
        chk(rxn == rx0, "R6 nothing forwarded on send", rxn - rx0, 0);
        chk(cs_n && !busy, "R8 bus released after frame", {cs_n, busy}, 2);
        exp_fid = (exp_fid + 1) % 64;
    endtask

    task automatic run_rx(input int len);
        int d0, rx0, f0, cyc, n, errs;
        d0 = donecnt; rx0 = rxn; f0 = gcount;
        @(negedge clk);
        rx_req = 1'b1; rx_len = 16'(len);
        @(negedge clk);
        rx_req = 1'b0;
        cyc = 0;
        while (donecnt == d0 && cyc < 20000) begin @(negedge clk); cyc++; end
        chk(cyc < 20000, "R10 fetch frame completes", cyc, 20000);
        repeat (4) @(negedge clk);
        n = gcount - f0;
        chk(n == 9 + len, "R5 R12 fetch byte count", n, 9 + len);
        chk(gb(f0) == 8'h80, "R5 read opcode", gb(f0), 8'h80);
        errs = 0;
        for (int i = 1; i < 9 + len; i++) if (gb(f0 + i) != 8'h00) errs++;
        chk(errs == 0, "R5 zero prefix and fill", errs, 0);
        chk(rxn - rx0 == len, "R6 forwarded count", rxn - rx0, len);
        errs = 0;
        for (int i = 0; i < len; i++) if (rxbuf[(rx0 + i) % 256] != pat(9 + i)) errs++;
        chk(errs == 0, "R6 R7 forwarded values", errs, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        run_tx(6, 6, 0);
        run_tx(300, 4, 0);
        run_tx(11, 11, 1);
        run_tx(60, 0, 0);
        run_rx(5);
        run_rx(0);
        run_tx(3, 3, 0);          // R3: tag unchanged by fetch frames
        run_tx(8, 8, 2);
        run_tx(2, 2, 3);
        run_rx(12);
        for (int k = 0; k < 64; k++) run_tx(64, 0, 0);   // R3 wrap
        run_tx(1, 1, 0);
        chk(stray == 0, "R8 no clock without select", stray, 0);
        chk(sclk == 1'b0, "R7 clock idles low", sclk, 0);
        chk(donecnt == frames, "R10 one done per frame", donecnt, frames);
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end
endmodule